// File: doc/BRIEF.md
# Serial Byte-Memory Command Controller

This block is the slave-side front end of a serial memory that holds 512 bytes. A host talks to it over a four-wire serial link with an active-low select, an active-low pause input, and clock polarity/phase either both 0 or both 1. The block oversamples the link pins in the system clock domain and finds the serial clock edges. It decodes the single command byte of each select period and then moves bytes between the link and a synchronous byte-wide RAM port. The start address is 9 bits wide: its top bit comes from bit 3 of the command byte and its low eight bits from the byte that follows.

Every byte to be stored is first offered to a neighbouring protection block as a permission request carrying the target address. The RAM write is only issued when that block grants it. Commands that touch the write-enable latch or the status byte are passed to the same neighbour as one-cycle strobes, and the neighbour supplies the status byte that is read back. A transfer streams for as long as the host keeps clocking. The address steps by one per byte and folds from the last location to the first.

Top module: `spi_mem_ctrl`

## Requirements
- R1: Command byte 0x06 gives exactly one single-cycle pulse on `wel_set`, and command byte 0x04 gives exactly one single-cycle pulse on `wel_clr`. Neither command takes further bytes.
- R2: Command byte 0x05 is followed by exactly one output byte, which is `stat_rdata`, sent MSB first. Each bit changes on a falling serial clock edge. After that byte the output enable stays low.
- R3: Command byte 0x01 takes the next byte and presents it on `stat_wdata` with a single-cycle `stat_wr` pulse.
- R4: Command byte 0000_A010 starts a store whose start address is {A, next byte}. Each complete data byte raises `wr_perm_req` with its address. `ram_we` follows for that address and data only in the cycle after a request that `wr_perm_ok` granted.
- R5: During a store or a fetch the address steps by one per byte with no limit on the byte count, and address 0x1FF is followed by 0x000.
- R6: Command byte 0000_A011 starts a fetch from {A, next byte}. The RAM bytes are returned MSB first, one bit per serial clock.
- R7: Only the first byte after a select falling edge is decoded. Bytes after a completed command, and everything after an undefined command byte, cause no strobe, no RAM write and no output, until select rises.
- R8: A data byte cut short by select rising causes no permission request and no RAM write.
- R9: `spi_so_en` is low while select is high, while the pause input is active, and at every point that is not a fetch or status output bit.
- R10: While the pause input is low, serial clock edges are ignored. When it is released the transfer resumes at the same bit, so the byte that was paused is transferred intact.
- R11: With the serial clock idling high, the falling edge that comes before the first rising edge is ignored. A fetch gives the same bytes as it does with the clock idling low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Drive enable for `spi_so` |
| wel_set | output | 1 | Pulse: set write-enable latch |
| wel_clr | output | 1 | Pulse: clear write-enable latch |
| stat_wr | output | 1 | Pulse: status byte write |
| stat_wdata | output | 8 | Status byte to write |
| stat_rdata | input | 8 | Current status byte |
| wr_perm_req | output | 1 | Permission request for a byte store |
| wr_perm_addr | output | 9 | Address of the requested store |
| wr_perm_ok | input | 1 | Same-cycle grant for the request |
| ram_addr | output | 9 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read strobe, data one cycle later |
| ram_rdata | input | 8 | RAM read data |

## Verification
The assertions assume the link pins are quasi-static compared with `clk`. Each serial clock level lasts at least six system clocks, so a RAM prefetch settles before the next falling edge. Pause changes only while the serial clock is low, and the grant input answers the request in the same cycle. The bench changes every link pin on the falling system clock edge and holds each serial clock level for eight system clocks. It moves the pause input only while the serial clock is low and keeps select steady across any serial clock edge.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_WEL_SET = 8'h06;
  localparam logic [7:0] CMD_WEL_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD = 8'h05;
  localparam logic [7:0] CMD_STAT_WR = 8'h01;
  // memory commands: 0000_A01x, bit3 = address MSB, bit0 = fetch
  localparam logic [7:0] CMD_MEM_MASK = 8'hF6;
  localparam logic [7:0] CMD_MEM_VAL  = 8'h02;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_STORE, ST_FETCH, ST_STRD, ST_STWR, ST_DONE
  } seq_st_t;
endpackage

// File: rtl/smc_front.sv
module smc_front (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic si,
  output logic active,
  output logic held,
  output logic rise,
  output logic fall,
  output logic si_s
);
  logic sck_q, sck_p, cs_q, hold_q, seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      sck_p     <= 1'b0;
      cs_q      <= 1'b1;
      hold_q    <= 1'b1;
      si_s      <= 1'b0;
      held      <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_p  <= sck_q;
      cs_q   <= cs_n;
      hold_q <= hold_n;
      si_s   <= si;
      // pause state only changes while the serial clock is low
      if (!sck_q) held <= !hold_q;
      if (cs_q) seen_rise <= 1'b0;
      else if (rise) seen_rise <= 1'b1;
    end
  end

  assign active = !cs_q;
  assign rise   = active && !held && sck_q && !sck_p;
  // first falling edge with clock idling high is dropped
  assign fall   = active && !held && !sck_q && sck_p && seen_rise;
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          held,
  input  logic          rise,
  input  logic          fall,
  input  logic          si_s,
  input  logic [BW-1:0] stat_rdata,
  input  logic          perm_ok,
  input  logic [BW-1:0] ram_rdata,
  output logic          so,
  output logic          so_en,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          stat_wr,
  output logic [BW-1:0] stat_wdata,
  output logic          perm_req,
  output logic [AW-1:0] perm_addr,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [BW-1:0] ram_wdata,
  output logic          ram_re
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST_BIT = CW'(BW - 1);

  seq_st_t       st;
  logic [CW-1:0] bitcnt;
  logic [BW-2:0] rx;
  logic [BW-1:0] tx, rd_buf, wbuf;
  logic [AW-1:0] ptr;
  logic          a_hi, fetch_sel, rd_on, re_d;
  logic [BW-1:0] byte_in;
  logic          byte_done, out_st;

  assign byte_in   = {rx, si_s};
  assign byte_done = rise && (bitcnt == LAST_BIT);
  assign out_st    = (st == ST_FETCH) || (st == ST_STRD);
  assign so        = tx[BW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_CMD; bitcnt <= '0; rx <= '0; tx <= '0; rd_buf <= '0;
      wbuf <= '0; ptr <= '0; a_hi <= 1'b0; fetch_sel <= 1'b0;
      rd_on <= 1'b0; re_d <= 1'b0; so_en <= 1'b0;
      wel_set <= 1'b0; wel_clr <= 1'b0; stat_wr <= 1'b0; stat_wdata <= '0;
      perm_req <= 1'b0; perm_addr <= '0;
      ram_addr <= '0; ram_we <= 1'b0; ram_wdata <= '0; ram_re <= 1'b0;
    end else begin
      wel_set <= 1'b0; wel_clr <= 1'b0; stat_wr <= 1'b0;
      perm_req <= 1'b0; ram_we <= 1'b0; ram_re <= 1'b0;
      re_d <= ram_re;
      if (re_d) rd_buf <= ram_rdata;
      // granted store commits one cycle after the request
      if (perm_req && perm_ok) begin
        ram_we    <= 1'b1;
        ram_addr  <= perm_addr;
        ram_wdata <= wbuf;
      end
      if (!active) begin
        st     <= ST_CMD;
        bitcnt <= '0;
        rd_on  <= 1'b0;
      end else begin
        if (rise) begin
          rx     <= byte_in[BW-2:0];
          bitcnt <= bitcnt + 1'b1;
        end
        if (byte_done) begin
          case (st)
            ST_CMD: begin
              if (byte_in == CMD_WEL_SET) begin
                wel_set <= 1'b1; st <= ST_DONE;
              end else if (byte_in == CMD_WEL_CLR) begin
                wel_clr <= 1'b1; st <= ST_DONE;
              end else if (byte_in == CMD_STAT_RD) begin
                st <= ST_STRD;
              end else if (byte_in == CMD_STAT_WR) begin
                st <= ST_STWR;
              end else if ((byte_in & CMD_MEM_MASK) == CMD_MEM_VAL) begin
                a_hi      <= byte_in[3];
                fetch_sel <= byte_in[0];
                st        <= ST_ADDR;
              end else begin
                st <= ST_DONE;
              end
            end
            ST_ADDR: begin
              if (fetch_sel) begin
                ram_addr <= {a_hi, byte_in};
                ram_re   <= 1'b1;
                ptr      <= {a_hi, byte_in} + AW'(1);
                st       <= ST_FETCH;
              end else begin
                ptr <= {a_hi, byte_in};
                st  <= ST_STORE;
              end
            end
            ST_STORE: begin
              perm_req  <= 1'b1;
              perm_addr <= ptr;
              wbuf      <= byte_in;
              ptr       <= ptr + AW'(1);
            end
            ST_FETCH: begin
              ram_addr <= ptr;
              ram_re   <= 1'b1;
              ptr      <= ptr + AW'(1);
            end
            ST_STRD: st <= ST_DONE;
            ST_STWR: begin
              stat_wr    <= 1'b1;
              stat_wdata <= byte_in;
              st         <= ST_DONE;
            end
            ST_DONE: ;
            default: st <= ST_DONE;
          endcase
        end
        if (fall && out_st) begin
          if (bitcnt == '0) begin
            tx    <= (st == ST_STRD) ? stat_rdata : rd_buf;
            rd_on <= 1'b1;
          end else begin
            tx <= {tx[BW-2:0], 1'b0};
          end
        end
      end
      so_en <= active && rd_on && !held && out_st;
    end
  end

  // R4
  we_granted_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(perm_req && perm_ok));
  // R4
  we_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr == $past(perm_addr)));
  // R9
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !so_en);
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (active && held) |=> ($stable(bitcnt) && $stable(tx)));
  // R8
  no_req_unsel_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !perm_req);
  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wel_set, wel_clr, stat_wr, perm_req, ram_re}));
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_en,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              stat_wr,
  output logic [BYTE_W-1:0] stat_wdata,
  input  logic [BYTE_W-1:0] stat_rdata,
  output logic              wr_perm_req,
  output logic [ADDR_W-1:0] wr_perm_addr,
  input  logic              wr_perm_ok,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ram_re,
  input  logic [BYTE_W-1:0] ram_rdata
);
  logic active, held, rise, fall, si_s;

  smc_front u_front (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n),
    .hold_n(spi_hold_n), .si(spi_si), .active(active), .held(held),
    .rise(rise), .fall(fall), .si_s(si_s)
  );

  smc_seq #(.AW(ADDR_W), .BW(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .active(active), .held(held), .rise(rise),
    .fall(fall), .si_s(si_s), .stat_rdata(stat_rdata),
    .perm_ok(wr_perm_ok), .ram_rdata(ram_rdata), .so(spi_so),
    .so_en(spi_so_en), .wel_set(wel_set), .wel_clr(wel_clr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .perm_req(wr_perm_req),
    .perm_addr(wr_perm_addr), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_re(ram_re)
  );
endmodule

// File: tb/spi_mem_ctrl_tb.sv
module spi_mem_ctrl_tb;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic so, so_en, wel_set, wel_clr, stat_wr, perm_req, perm_ok;
  logic ram_we, ram_re;
  logic [7:0] stat_wdata, stat_rdata, ram_wdata, ram_rdata;
  logic [8:0] perm_addr, ram_addr;
  logic [7:0] ram [0:511];
  logic       pl_en = 1'b0;
  logic [8:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  int lock_base = 512;
  int checks = 0, failures = 0;
  int n_set = 0, n_clr = 0, n_swr = 0, n_req = 0, n_we = 0;
  logic [7:0] last_sw = '0;
  logic m3 = 1'b0;

  always #4 clk = ~clk;

  spi_mem_ctrl u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .spi_si(si), .spi_so(so), .spi_so_en(so_en),
    .wel_set(wel_set), .wel_clr(wel_clr), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .wr_perm_req(perm_req), .wr_perm_addr(perm_addr), .wr_perm_ok(perm_ok),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_rdata(ram_rdata)
  );

  assign perm_ok = perm_req && (int'(perm_addr) < lock_base);

  always @(posedge clk) begin
    if (pl_en) ram[pl_addr] <= pl_data;
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= ram[ram_addr];
    if (!rst) begin
      if (wel_set) n_set = n_set + 1;
      if (wel_clr) n_clr = n_clr + 1;
      if (stat_wr) begin n_swr = n_swr + 1; last_sw = stat_wdata; end
      if (perm_req) n_req = n_req + 1;
      if (ram_we) n_we = n_we + 1;
    end
  end

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    pl_en = 1'b1; pl_addr = 9'(a); pl_data = d;
    wc(1);
    pl_en = 1'b0;
  endtask

  task automatic sel(input logic mode3);
    m3 = mode3;
    sck = mode3;
    wc(H);
    cs_n = 1'b0;
    wc(H);
  endtask

  task automatic desel();
    if (!m3) begin sck = 1'b0; wc(H); end
    cs_n = 1'b1;
    wc(2 * H);
  endtask

  task automatic xfer(input logic [7:0] d, input int nb, input int hold_at,
                      output logic [7:0] q, output int oe_cnt);
    q = '0; oe_cnt = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = d[i];
      wc(H);
      if (i == hold_at) begin
        hold_n = 1'b0; wc(H);
        chk("R9 enable low in pause", int'(so_en), 0);
        sck = 1'b1; si = ~d[i]; wc(H);
        sck = 1'b0; wc(H);
        sck = 1'b1; wc(H);
        sck = 1'b0; si = d[i]; wc(H);
        hold_n = 1'b1; wc(H);
      end
      q[i] = so;
      if (so_en) oe_cnt++;
      sck = 1'b1;
      wc(H);
    end
  endtask

  task automatic put(input logic [7:0] d);
    logic [7:0] q; int c;
    xfer(d, 8, -1, q, c);
  endtask

  task automatic t_reset();
    chk("R9 reset enable", int'(so_en), 0);
    chk("R4 reset write", int'(ram_we), 0);
    chk("R4 reset request", int'(perm_req), 0);
  endtask

  task automatic t_wel();
    int s0 = n_set, c0 = n_clr;
    sel(1'b0); put(8'h06); put(8'h06); put(8'h04); desel();
    chk("R1 set pulse", n_set - s0, 1);
    chk("R7 no second command", n_clr - c0, 0);
    sel(1'b1); put(8'h04); desel();
    chk("R1 clear pulse", n_clr - c0, 1);
  endtask

  task automatic t_stat_rd();
    logic [7:0] q; int c;
    stat_rdata = 8'hA5;
    sel(1'b0); put(8'h05);
    xfer(8'h00, 8, -1, q, c);
    chk("R2 status byte", int'(q), 8'hA5);
    chk("R2 enable per bit", c, 8);
    xfer(8'h00, 8, -1, q, c);
    chk("R2 single byte only", c, 0);
    desel();
    chk("R9 enable after deselect", int'(so_en), 0);
  endtask

  task automatic t_stat_wr();
    int s0 = n_swr;
    sel(1'b0); put(8'h01); put(8'h3C); put(8'h77); desel();
    chk("R3 status write pulse", n_swr - s0, 1);
    chk("R3 status write data", int'(last_sw), 8'h3C);
  endtask

  task automatic t_store_wrap();
    int r0 = n_req;
    lock_base = 512;
    sel(1'b0); put(8'h0A); put(8'hFE); put(8'h11); put(8'h22); put(8'h33); desel();
    chk("R4 store 1FE", int'(ram[9'h1FE]), 8'h11);
    chk("R5 store 1FF", int'(ram[9'h1FF]), 8'h22);
    chk("R5 store wraps to 000", int'(ram[9'h000]), 8'h33);
    chk("R4 one request per byte", n_req - r0, 3);
  endtask

  task automatic t_fetch(input logic mode3, input int a, input string tag);
    logic [7:0] q; int c;
    poke(a, 8'h5A); poke((a + 1) % 512, 8'hC3); poke((a + 2) % 512, 8'h96);
    sel(mode3);
    put({4'h0, 1'(a >> 8), 3'b011});
    put(8'(a));
    xfer(8'hFF, 8, -1, q, c);
    chk({tag, " byte 0"}, int'(q), 8'h5A);
    xfer(8'h00, 8, -1, q, c);
    chk({tag, " byte 1"}, int'(q), 8'hC3);
    xfer(8'h00, 8, -1, q, c);
    chk({tag, " byte 2"}, int'(q), 8'h96);
    chk("R9 enable during fetch", c, 8);
    desel();
  endtask

  task automatic t_protect();
    int w0 = n_we;
    poke(9'h100, 8'hEE);
    lock_base = 9'h100;
    sel(1'b0); put(8'h02); put(8'hFF); put(8'h77); put(8'h88); desel();
    chk("R4 granted byte stored", int'(ram[9'h0FF]), 8'h77);
    chk("R4 refused byte kept", int'(ram[9'h100]), 8'hEE);
    chk("R4 one write issued", n_we - w0, 1);
    lock_base = 512;
  endtask

  task automatic t_partial();
    logic [7:0] q; int c;
    int r0 = n_req;
    poke(9'h010, 8'hAA);
    sel(1'b0); put(8'h02); put(8'h10);
    xfer(8'h55, 5, -1, q, c);
    desel();
    chk("R8 no request", n_req - r0, 0);
    chk("R8 location unchanged", int'(ram[9'h010]), 8'hAA);
  endtask

  task automatic t_unknown();
    logic [7:0] q; int c;
    int w0 = n_we, s0 = n_set, k0 = n_swr;
    sel(1'b0); put(8'hFF); put(8'h02); put(8'h06);
    xfer(8'h01, 8, -1, q, c);
    desel();
    chk("R7 unknown: no write", n_we - w0, 0);
    chk("R7 unknown: no strobe", (n_set - s0) + (n_swr - k0), 0);
    chk("R7 unknown: no output", c, 0);
  endtask

  task automatic t_pause();
    logic [7:0] q; int c;
    poke(9'h020, 8'hB7);
    sel(1'b0); put(8'h03); put(8'h20);
    xfer(8'h00, 8, 4, q, c);
    desel();
    chk("R10 fetch across pause", int'(q), 8'hB7);
    sel(1'b0); put(8'h02); put(8'h30);
    xfer(8'h6D, 8, 3, q, c);
    desel();
    chk("R10 store across pause", int'(ram[9'h030]), 8'h6D);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    stat_rdata = 8'h00;
    wc(5);
    rst = 1'b0;
    wc(2);
    t_reset();
    t_wel();
    t_stat_rd();
    t_stat_wr();
    t_store_wrap();
    t_fetch(1'b0, 9'h1FF, "R6 R5 fetch wrap");
    t_fetch(1'b1, 9'h0A3, "R11 fetch idle-high clock");
    t_protect();
    t_partial();
    t_unknown();
    t_pause();
    chk("R9 idle enable", int'(so_en), 0);
    finish_run();
  end
endmodule